// File: doc/BRIEF.md
# Interrupt-Gated DMA Request Generator

This block paces the DMA traffic of a two-direction sample stream. On every sample tick it raises a playback request and a capture request for each direction that is enabled. Each request stays up until the bus side acknowledges it. A down-counter tracks the remaining transfers. When the counter expires, it reloads from a programmed base value and raises a sticky interrupt flag. Software clears the flag with a dedicated strobe.

A gating control lets the interrupt flag stall the whole stream. When the gate input and the flag are both high, no new request is issued and the counter is frozen. A request that is already outstanding still runs to its acknowledge. Once a direction has no outstanding request, the block tells the data path to play midscale or to hold the last capture sample. Dropping the gate, or clearing the flag, lifts the stall.

Each direction is run by its own small state machine with three states:
- CH_IDLE waits for a tick.
- CH_REQ drives the request.
- CH_STALL marks a parked direction.

Transitions:
- CH_IDLE to CH_REQ on an enabled tick while not stalled.
- CH_IDLE to CH_STALL when a stall is present.
- CH_REQ to CH_IDLE on an acknowledge with no stall.
- CH_REQ to CH_STALL on an acknowledge under stall.
- CH_STALL to CH_REQ when the stall has lifted and an enabled tick arrives.
- CH_STALL to CH_IDLE when the stall has lifted and no such tick arrives.

Top module: `dma_req_gate`

## Requirements
- R1: After reset, both request lines, the interrupt flag, both stall indications and the count are all 0.
- R2: With `gate_en` at 0, a `smp_tick` while a direction is enabled raises that direction's request on the following cycle, whatever the value of the interrupt flag.
- R3: A request stays high until its acknowledge is sampled, and drops on the cycle after. Without a new tick, no new request is raised.
- R4: An eligible tick decrements the count by one. A tick is eligible when at least one direction is enabled and the block is not stalled. With both directions disabled, a tick leaves the count unchanged.
- R5: An eligible tick that finds the count at 0 reloads the count from the base register and sets the interrupt flag. Starting from a base of N, the flag therefore rises on tick N+1.
- R6: The interrupt flag falls only on an `irq_clr` strobe. When a strobe coincides with a new interrupt, the flag ends up set.
- R7: While `gate_en` and the interrupt flag are both 1, ticks raise no new request and the count holds.
- R8: A request that is outstanding when the stall begins stays high until its acknowledge arrives.
- R9: Under stall, a direction with no outstanding request shows its indication (`dac_midscale` for playback, `adc_hold` for capture) starting on the cycle after its acknowledge. While a request is pending, the indication stays low.
- R10: Clearing `gate_en` drops the indications one cycle later. An `irq_clr` drops them two cycles later. In both cases, later ticks raise requests again.
- R11: `base_wr` loads `base_val` into both the base register and the count on the next cycle. For the count, the load takes precedence over a simultaneous tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | One-cycle sample period strobe |
| play_en | input | 1 | Playback direction enable |
| cap_en | input | 1 | Capture direction enable |
| gate_en | input | 1 | Lets the interrupt flag stall requests and counting |
| play_ack | input | 1 | Playback request acknowledge |
| cap_ack | input | 1 | Capture request acknowledge |
| irq_clr | input | 1 | Strobe that clears the interrupt flag |
| base_wr | input | 1 | Strobe that loads the base value |
| base_val | input | CNT_W | Base count value |
| play_req | output | 1 | Playback DMA request |
| cap_req | output | 1 | Capture DMA request |
| irq_flag | output | 1 | Sticky interrupt flag |
| dac_midscale | output | 1 | Playback stalled; feed midscale to the DAC |
| adc_hold | output | 1 | Capture stalled; hold the last ADC sample |
| dma_count | output | CNT_W | Current DMA count |

## Verification
The assertions assume that an acknowledge is only raised while its request is high. They also assume that `smp_tick`, `irq_clr` and `base_wr` are single-cycle strobes. The bench keeps to both assumptions. It pulses each strobe for exactly one cycle and raises an acknowledge only after it has seen the matching request high. The counter sweep varies the base value and the enable pattern. Stall stimulus always completes or acknowledges any pending request before it checks the stall indications.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    localparam int NUM_DIR = 2;
    localparam int DIR_PLAY = 0;
    localparam int DIR_CAP = 1;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_REQ   = 2'd1,
        CH_STALL = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dmag_channel.sv
module dmag_channel
    import dmag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic ack,
    input  logic stall,
    output logic req,
    output logic park
);
    ch_state_e state_q;
    ch_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (stall) begin
                    state_d = CH_STALL;
                end else if (tick && en) begin
                    state_d = CH_REQ;
                end
            end
            CH_REQ: begin
                // an outstanding request always runs to its acknowledge
                if (ack) begin
                    state_d = stall ? CH_STALL : CH_IDLE;
                end
            end
            CH_STALL: begin
                if (!stall) begin
                    state_d = (tick && en) ? CH_REQ : CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req  = (state_q == CH_REQ);
        park = (state_q == CH_STALL);
    end
endmodule

// File: rtl/dmag_counter.sv
module dmag_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             any_en,
    input  logic             stall,
    input  logic             base_wr,
    input  logic [CNT_W-1:0] base_val,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] count_q;
    logic             irq_q;
    logic             advance;
    logic             wrap;

    always_comb begin
        advance = tick && any_en && !stall;
        wrap    = advance && (count_q == ZERO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= ZERO;
            count_q <= ZERO;
            irq_q   <= 1'b0;
        end else begin
            if (base_wr) begin
                base_q <= base_val;
            end

            if (base_wr) begin
                count_q <= base_val;
            end else if (wrap) begin
                count_q <= base_q;
            end else if (advance) begin
                count_q <= count_q - ONE;
            end

            // a new interrupt wins over a clear in the same cycle
            if (wrap) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        count = count_q;
        irq   = irq_q;
    end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
    import dmag_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_tick,
    input  logic             play_en,
    input  logic             cap_en,
    input  logic             gate_en,
    input  logic             play_ack,
    input  logic             cap_ack,
    input  logic             irq_clr,
    input  logic             base_wr,
    input  logic [CNT_W-1:0] base_val,
    output logic             play_req,
    output logic             cap_req,
    output logic             irq_flag,
    output logic             dac_midscale,
    output logic             adc_hold,
    output logic [CNT_W-1:0] dma_count
);
    logic [NUM_DIR-1:0] dir_en;
    logic [NUM_DIR-1:0] dir_ack;
    logic [NUM_DIR-1:0] dir_req;
    logic [NUM_DIR-1:0] dir_park;
    logic               irq_w;
    logic               stall;

    always_comb begin
        dir_en[DIR_PLAY]  = play_en;
        dir_en[DIR_CAP]   = cap_en;
        dir_ack[DIR_PLAY] = play_ack;
        dir_ack[DIR_CAP]  = cap_ack;
        stall             = gate_en && irq_w;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        dmag_channel u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (smp_tick),
            .en    (dir_en[d]),
            .ack   (dir_ack[d]),
            .stall (stall),
            .req   (dir_req[d]),
            .park  (dir_park[d])
        );
    end

    dmag_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (smp_tick),
        .any_en   (|dir_en),
        .stall    (stall),
        .base_wr  (base_wr),
        .base_val (base_val),
        .irq_clr  (irq_clr),
        .count    (dma_count),
        .irq      (irq_w)
    );

    always_comb begin
        play_req     = dir_req[DIR_PLAY];
        cap_req      = dir_req[DIR_CAP];
        dac_midscale = dir_park[DIR_PLAY];
        adc_hold     = dir_park[DIR_CAP];
        irq_flag     = irq_w;
    end
endmodule

// File: rtl/dma_req_gate_chk.sv
module dma_req_gate_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_tick,
    input logic             play_en,
    input logic             cap_en,
    input logic             gate_en,
    input logic             play_ack,
    input logic             cap_ack,
    input logic             irq_clr,
    input logic             base_wr,
    input logic [CNT_W-1:0] base_val,
    input logic             play_req,
    input logic             cap_req,
    input logic             irq_flag,
    input logic             dac_midscale,
    input logic             adc_hold,
    input logic [CNT_W-1:0] dma_count
);
    a_r3_play_held: assert property (@(posedge clk) disable iff (!rst_n)
        play_req && !play_ack |=> play_req);
    a_r3_cap_held: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req && !cap_ack |=> cap_req);
    a_r2_play_raise: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick && play_en && !(gate_en && irq_flag) && !play_req |=> play_req);
    a_r7_no_new_play: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en && irq_flag && !play_req |=> !play_req);
    a_r7_no_new_cap: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en && irq_flag && !cap_req |=> !cap_req);
    a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en && irq_flag && !base_wr |=> $stable(dma_count));
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clr |=> irq_flag);
    a_r11_base_load: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> dma_count == $past(base_val));
    a_r9_mid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_midscale && play_req) && !(adc_hold && cap_req));
endmodule

bind dma_req_gate dma_req_gate_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_req_gate_tb_top.sv
module dma_req_gate_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_tick = 1'b0;
    logic          play_en = 1'b0;
    logic          cap_en = 1'b0;
    logic          gate_en = 1'b0;
    logic          play_ack = 1'b0;
    logic          cap_ack = 1'b0;
    logic          irq_clr = 1'b0;
    logic          base_wr = 1'b0;
    logic [CW-1:0] base_val = '0;
    logic          play_req;
    logic          cap_req;
    logic          irq_flag;
    logic          dac_midscale;
    logic          adc_hold;
    logic [CW-1:0] dma_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_req_gate #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .play_en(play_en),
        .cap_en(cap_en), .gate_en(gate_en), .play_ack(play_ack), .cap_ack(cap_ack),
        .irq_clr(irq_clr), .base_wr(base_wr), .base_val(base_val),
        .play_req(play_req), .cap_req(cap_req), .irq_flag(irq_flag),
        .dac_midscale(dac_midscale), .adc_hold(adc_hold), .dma_count(dma_count)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic pulse_tick();
        smp_tick = 1'b1; cyc(); smp_tick = 1'b0;
    endtask

    task automatic ack_both();
        play_ack = play_req; cap_ack = cap_req; cyc();
        play_ack = 1'b0; cap_ack = 1'b0;
    endtask

    task automatic load_base(input int v);
        base_val = CW'(v); base_wr = 1'b1; cyc(); base_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        eq("R1 play_req", int'(play_req), 0);
        eq("R1 cap_req", int'(cap_req), 0);
        eq("R1 irq", int'(irq_flag), 0);
        eq("R1 mid", int'(dac_midscale), 0);
        eq("R1 hold", int'(adc_hold), 0);
        eq("R1 count", int'(dma_count), 0);
        rst_n = 1'b1;
        cyc();

        // R11 load
        load_base(3);
        eq("R11 count load", int'(dma_count), 3);

        // R2 R4 R5 R6 sweep over base value and enable pattern
        for (int n = 1; n <= 4; n++) begin
            play_en = 1'b1;
            cap_en  = n[0];
            load_base(n);
            for (int k = 1; k <= n + 1; k++) begin
                pulse_tick();
                eq("R2 play_req raised", int'(play_req), 1);
                eq("R2 cap_req follows enable", int'(cap_req), int'(cap_en));
                eq("R4 R5 count", int'(dma_count), (k <= n) ? n - k : n);
                eq("R5 irq", int'(irq_flag), (k == n + 1) ? 1 : 0);
                ack_both();
                eq("R3 play drop after ack", int'(play_req), 0);
            end
            // flag set with gate low must not block requests (R2)
            pulse_tick();
            eq("R2 request despite irq", int'(play_req), 1);
            ack_both();
            cyc();
            eq("R6 irq sticky", int'(irq_flag), 1);
            irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
            eq("R6 irq cleared", int'(irq_flag), 0);
        end

        // R3 hold until ack, one request per tick
        cap_en = 1'b0;
        pulse_tick();
        for (int i = 0; i < 3; i++) begin
            cyc();
            eq("R3 req held", int'(play_req), 1);
        end
        ack_both();
        for (int i = 0; i < 3; i++) begin
            eq("R3 no request without tick", int'(play_req), 0);
            cyc();
        end

        // R4 no enable: count unchanged
        play_en = 1'b0;
        load_base(7);
        pulse_tick();
        eq("R4 count hold when disabled", int'(dma_count), 7);
        eq("R4 no req when disabled", int'(play_req), 0);

        // R6 set wins over clear
        play_en = 1'b1;
        load_base(0);
        smp_tick = 1'b1; irq_clr = 1'b1; cyc(); smp_tick = 1'b0; irq_clr = 1'b0;
        eq("R6 set beats clear", int'(irq_flag), 1);
        ack_both();

        // R7 R9 stall
        cap_en = 1'b1;
        load_base(5);
        gate_en = 1'b1;
        cyc();
        eq("R9 midscale under stall", int'(dac_midscale), 1);
        eq("R9 hold under stall", int'(adc_hold), 1);
        pulse_tick();
        cyc();
        eq("R7 no play req", int'(play_req), 0);
        eq("R7 no cap req", int'(cap_req), 0);
        eq("R7 count frozen", int'(dma_count), 5);

        // R8 pending requests complete under stall
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        load_base(0);
        pulse_tick();
        eq("R8 irq set by wrap", int'(irq_flag), 1);
        for (int i = 0; i < 2; i++) begin
            cyc();
            eq("R8 play pending", int'(play_req), 1);
            eq("R8 cap pending", int'(cap_req), 1);
            eq("R9 no mid while pending", int'(dac_midscale), 0);
        end
        play_ack = 1'b1; cyc(); play_ack = 1'b0;
        eq("R8 play done", int'(play_req), 0);
        eq("R9 mid after ack", int'(dac_midscale), 1);
        eq("R8 cap still pending", int'(cap_req), 1);
        eq("R9 no hold while pending", int'(adc_hold), 0);
        cap_ack = 1'b1; cyc(); cap_ack = 1'b0;
        eq("R9 hold after ack", int'(adc_hold), 1);

        // R10 resume via gate, then via clear
        gate_en = 1'b0;
        cyc();
        eq("R10 mid off after gate clear", int'(dac_midscale), 0);
        eq("R10 hold off after gate clear", int'(adc_hold), 0);
        pulse_tick();
        eq("R10 play resumes", int'(play_req), 1);
        eq("R10 cap resumes", int'(cap_req), 1);
        ack_both();
        gate_en = 1'b1;
        cyc();
        eq("R9 mid stall again", int'(dac_midscale), 1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        cyc();
        eq("R10 mid off after irq clear", int'(dac_midscale), 0);
        pulse_tick();
        eq("R10 play resumes after clear", int'(play_req), 1);
        ack_both();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule